// File: doc/BRIEF.md
# Split internal data memory decoder

This block holds the 256-byte on-chip data RAM of an 8-bit controller and decides, for each access, where that access lands. The lower half of the address range, 00H to 7FH, is plain RAM whatever the addressing mode. The upper half, 80H to FFH, is shared by two separate stores: the upper 128 bytes of RAM and the special-function-register space. Only the addressing mode picks between them. A direct access goes out on the register-bus port. An indirect access goes to upper RAM. The address alone never decides.

A second port serves a hardware stack. Its pointer moves up on push and down on pop, and its accesses always behave as indirect ones. The stack can therefore grow past 7FH into upper RAM without disturbing any register. The register contents themselves live outside the block, behind the register-bus port. The access port and the stack port may both act in the same cycle.

Top module: `idata_space_router`

## Requirements
- R1: While rst_n is low at a clock edge, the block resets. Afterwards sp_value is 07H, and rd_valid, rd_data and pop_data are all 0.
- R2: An address 00H-7FH reaches the same RAM byte in direct mode (acc_indirect=0) and in indirect mode (acc_indirect=1).
- R3: A direct access to an address of 80H or above drives the register bus in the same cycle: sfr_sel=1, sfr_addr=acc_addr, sfr_wdata=acc_wdata and sfr_we=acc_we. It does not write the RAM byte at that address.
- R4: An indirect access to an address of 80H or above reaches the upper RAM byte at that address. It leaves sfr_sel and sfr_we at 0.
- R5: A read (acc_valid=1, acc_we=0) raises rd_valid and presents rd_data in the following cycle, and rd_valid is 0 after any other cycle. For a direct read of 80H or above, rd_data is the sfr_rdata value sampled in the request cycle. For every other read it is the RAM byte.
- R6: A push alone (stk_push=1, stk_pop=0) first increments sp_value and then writes stk_wdata at the new pointer. The write is indirect, so a pointer of 80H or above addresses upper RAM.
- R7: A pop alone presents the byte at the current pointer on pop_data in the following cycle. It then decrements sp_value.
- R8: The stack pointer wraps modulo 256. A push from FFH writes byte 00H, and a pop from 00H leaves the pointer at FFH.
- R9: When stk_push and stk_pop are both 1, nothing happens. The pointer is unchanged and no byte is written.
- R10: When a read and a write hit the same byte in the same cycle, one through each port, the read returns the byte's old value.
- R11: When the access port and a push write the same byte in the same cycle, the access-port value is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_indirect | input | 1 | 1 = indirect mode, 0 = direct mode |
| acc_addr | input | 8 | Access address |
| acc_wdata | input | 8 | Access write data |
| stk_push | input | 1 | Push request |
| stk_pop | input | 1 | Pop request |
| stk_wdata | input | 8 | Data to push |
| sfr_sel | output | 1 | Register-bus access this cycle |
| sfr_we | output | 1 | Register-bus write strobe |
| sfr_addr | output | 8 | Register-bus address |
| sfr_wdata | output | 8 | Register-bus write data |
| sfr_rdata | input | 8 | Register-bus read return, same cycle |
| rd_data | output | 8 | Access read data, one cycle after request |
| rd_valid | output | 1 | rd_data carries a fresh read result |
| pop_data | output | 8 | Popped byte, one cycle after pop |
| sp_value | output | 8 | Current stack pointer |

## Verification
A wrong routing decision shows up in the same cycle at the register-bus pins, as a missing or spurious sfr_sel or sfr_we. The RAM damage it causes appears one cycle after a later indirect read of the same address. A stale or wrong pointer appears on sp_value one cycle after the push or pop that moved it. Its effect on stored data appears only when that byte is read back. For this reason the stack sequences cross 7FH/80H and FFH/00H and are checked against reads through the access port. Same-byte collisions between the two ports are checked in the cycle right after the collision, and again one read later.

// File: rtl/idata_pkg.sv
// Shared types for the internal data-space router.
// Assumes one 8-bit-style address space whose top address bit splits
// the lower RAM from the overlaid upper half.
package idata_pkg;
    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_RAM_LO = 2'd1,
        TGT_RAM_HI = 2'd2,
        TGT_SFR    = 2'd3
    } target_e;
endpackage

// File: rtl/idata_route_dec.sv
// Routing decoder: chooses lower RAM, upper RAM or the register bus for one access.
// Assumes the top address bit marks the overlaid half. In that half the
// addressing mode alone picks the store.
module idata_route_dec
    import idata_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              valid,
    input  logic              we,
    input  logic              indirect,
    input  logic [ADDR_W-1:0] addr,
    output logic              ram_re,
    output logic              ram_we,
    output logic              sfr_sel,
    output logic              sfr_we
);
    localparam int TOP_BIT = ADDR_W - 1;

    target_e tgt;

    // Pick the target store from the mode and the half of the address space.
    always_comb begin
        tgt = TGT_NONE;
        if (valid) begin
            if (!addr[TOP_BIT])  tgt = TGT_RAM_LO;
            else if (indirect)   tgt = TGT_RAM_HI;
            else                 tgt = TGT_SFR;
        end
    end

    // Turn the target into per-store strobes.
    always_comb begin
        ram_re  = ((tgt == TGT_RAM_LO) || (tgt == TGT_RAM_HI)) && !we;
        ram_we  = ((tgt == TGT_RAM_LO) || (tgt == TGT_RAM_HI)) && we;
        sfr_sel = (tgt == TGT_SFR);
        sfr_we  = (tgt == TGT_SFR) && we;
    end
endmodule

// File: rtl/idata_stack_ctl.sv
// Stack pointer control: pre-increment push, post-decrement pop, modulo wrap.
// Assumes push and pop together cancel out. Stack accesses are always
// indirect, so the pointer addresses RAM over its whole range.
module idata_stack_ctl #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SP_RESET = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    output logic [ADDR_W-1:0] sp,
    output logic              wr_en,
    output logic              rd_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // Decode a lone push or a lone pop and the addresses they use.
    always_comb begin
        wr_en   = push && !pop;
        rd_en   = pop && !push;
        wr_addr = sp + ONE;
        rd_addr = sp;
    end

    // Move the pointer; its width gives the modulo wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)     sp <= SP_RESET;
        else if (wr_en) sp <= sp + ONE;
        else if (rd_en) sp <= sp - ONE;
    end
endmodule

// File: rtl/idata_ram2p.sv
// Two-port data RAM with registered reads and read-before-write behaviour.
// Assumes port A wins when both ports write the same byte in one cycle.
// The array itself is not reset.
module idata_ram2p #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_re,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_q,
    input  logic              b_re,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store writes; port A is applied last so it takes priority.
    always_ff @(posedge clk) begin
        if (b_we) mem[b_addr] <= b_wdata;
        if (a_we) mem[a_addr] <= a_wdata;
    end

    // Register port A reads; this returns the value from before any same-edge write.
    always_ff @(posedge clk) begin
        if (!rst_n)    a_q <= '0;
        else if (a_re) a_q <= mem[a_addr];
    end

    // Register port B reads under the same rule.
    always_ff @(posedge clk) begin
        if (!rst_n)    b_q <= '0;
        else if (b_re) b_q <= mem[b_addr];
    end
endmodule

// File: rtl/idata_space_router.sv
// Internal data space top: lower and upper RAM plus a pass-through register bus.
// Assumes the register bus answers in the same cycle. All read results
// appear one cycle after the request. The stack port always acts indirectly.
module idata_space_router #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] SP_RESET = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic              acc_indirect,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              stk_push,
    input  logic              stk_pop,
    input  logic [DATA_W-1:0] stk_wdata,
    output logic              sfr_sel,
    output logic              sfr_we,
    output logic [ADDR_W-1:0] sfr_addr,
    output logic [DATA_W-1:0] sfr_wdata,
    input  logic [DATA_W-1:0] sfr_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] pop_data,
    output logic [ADDR_W-1:0] sp_value
);
    logic              ram_re, ram_we;
    logic              stk_wr_en, stk_rd_en;
    logic [ADDR_W-1:0] stk_wr_addr, stk_rd_addr;
    logic [ADDR_W-1:0] stk_addr;
    logic [DATA_W-1:0] ram_a_q;
    logic              from_sfr_q;
    logic [DATA_W-1:0] sfr_cap_q;

    idata_route_dec #(.ADDR_W(ADDR_W)) u_dec (
        .valid    (acc_valid),
        .we       (acc_we),
        .indirect (acc_indirect),
        .addr     (acc_addr),
        .ram_re   (ram_re),
        .ram_we   (ram_we),
        .sfr_sel  (sfr_sel),
        .sfr_we   (sfr_we)
    );

    idata_stack_ctl #(.ADDR_W(ADDR_W), .SP_RESET(SP_RESET)) u_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (stk_push),
        .pop     (stk_pop),
        .sp      (sp_value),
        .wr_en   (stk_wr_en),
        .rd_en   (stk_rd_en),
        .wr_addr (stk_wr_addr),
        .rd_addr (stk_rd_addr)
    );

    // Stack port address: the pre-incremented pointer for a push, the pointer itself otherwise.
    always_comb stk_addr = stk_wr_en ? stk_wr_addr : stk_rd_addr;

    idata_ram2p #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_re    (ram_re),
        .a_we    (ram_we),
        .a_addr  (acc_addr),
        .a_wdata (acc_wdata),
        .a_q     (ram_a_q),
        .b_re    (stk_rd_en),
        .b_we    (stk_wr_en),
        .b_addr  (stk_addr),
        .b_wdata (stk_wdata),
        .b_q     (pop_data)
    );

    // Pass the request through to the register bus.
    always_comb begin
        sfr_addr  = acc_addr;
        sfr_wdata = acc_wdata;
    end

    // Remember which store answered each read, and capture the register-bus return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            from_sfr_q <= 1'b0;
            sfr_cap_q  <= '0;
        end else begin
            rd_valid <= acc_valid && !acc_we;
            if (acc_valid && !acc_we) from_sfr_q <= sfr_sel;
            if (sfr_sel && !acc_we)   sfr_cap_q  <= sfr_rdata;
        end
    end

    // Choose the read result from RAM or the captured register value.
    always_comb rd_data = from_sfr_q ? sfr_cap_q : ram_a_q;
endmodule

// File: rtl/idata_space_router_chk.sv
// Checker for the data-space router: routing, read timing and pointer steps.
// Assumes it is bound to idata_space_router and only observes its ports.
module idata_space_router_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_we,
    input logic              acc_indirect,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              stk_push,
    input logic              stk_pop,
    input logic              sfr_sel,
    input logic              sfr_we,
    input logic [DATA_W-1:0] sfr_rdata,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] sp_value
);
    localparam int TOP_BIT = ADDR_W - 1;

    // R3
    sfr_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_indirect && acc_addr[TOP_BIT]) |-> sfr_sel);

    // R3
    sfr_we_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_we |-> (acc_valid && acc_we));

    // R4
    sfr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (acc_indirect || !acc_addr[TOP_BIT])) |-> (!sfr_sel && !sfr_we));

    // R5
    rd_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_we) |=> rd_valid);

    // R5
    rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_we) |=> !rd_valid);

    // R5
    sfr_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_we && !acc_indirect && acc_addr[TOP_BIT])
        |=> (rd_data == $past(sfr_rdata)));

    // R6
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_push && !stk_pop) |=> (sp_value == ADDR_W'($past(sp_value) + 1)));

    // R7
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_pop && !stk_push) |=> (sp_value == ADDR_W'($past(sp_value) - 1)));

    // R9
    sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_push == stk_pop) |=> $stable(sp_value));
endmodule

bind idata_space_router idata_space_router_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_we       (acc_we),
    .acc_indirect (acc_indirect),
    .acc_addr     (acc_addr),
    .stk_push     (stk_push),
    .stk_pop      (stk_pop),
    .sfr_sel      (sfr_sel),
    .sfr_we       (sfr_we),
    .sfr_rdata    (sfr_rdata),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .sp_value     (sp_value)
);

// File: tb/idata_space_router_tb.sv
// Directed bench for idata_space_router: one task per scenario.
module idata_space_router_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0, acc_we = 1'b0, acc_indirect = 1'b0;
    logic [7:0] acc_addr = '0, acc_wdata = '0;
    logic       stk_push = 1'b0, stk_pop = 1'b0;
    logic [7:0] stk_wdata = '0;
    logic       sfr_sel, sfr_we;
    logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
    logic [7:0] rd_data, pop_data, sp_value;
    logic       rd_valid;

    int   n_run = 0;
    int   n_fail = 0;
    logic [7:0] exp_sp = 8'h07;
    logic [7:0] q;

    always #2.5 clk = ~clk;

    // Bench register-bus model: each register reads back as its address XOR 5AH.
    assign sfr_rdata = sfr_addr ^ 8'h5A;

    idata_space_router u_dut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_we(acc_we), .acc_indirect(acc_indirect),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .stk_push(stk_push), .stk_pop(stk_pop), .stk_wdata(stk_wdata),
        .sfr_sel(sfr_sel), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .pop_data(pop_data), .sp_value(sp_value)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Drive both ports for one cycle, then sample just after the edge.
    task automatic cyc(input logic v, input logic we, input logic ind, input logic [7:0] a,
                       input logic [7:0] d, input logic psh, input logic pp, input logic [7:0] sd);
        @(negedge clk);
        acc_valid = v; acc_we = we; acc_indirect = ind; acc_addr = a; acc_wdata = d;
        stk_push = psh; stk_pop = pp; stk_wdata = sd;
        @(posedge clk); #1;
        acc_valid = 1'b0; acc_we = 1'b0; stk_push = 1'b0; stk_pop = 1'b0;
    endtask

    task automatic wr(input logic ind, input logic [7:0] a, input logic [7:0] d);
        cyc(1'b1, 1'b1, ind, a, d, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic rd(input logic ind, input logic [7:0] a, output logic [7:0] r);
        cyc(1'b1, 1'b0, ind, a, 8'h00, 1'b0, 1'b0, 8'h00);
        r = rd_data;
    endtask

    task automatic push(input logic [7:0] d);
        cyc(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, d);
        exp_sp = exp_sp + 8'd1;
    endtask

    task automatic pop();
        cyc(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00);
        exp_sp = exp_sp - 8'd1;
    endtask

    task automatic t_reset();
        chk("R1", "sp_value", sp_value, 8'h07);
        chk("R1", "rd_valid", {7'd0, rd_valid}, 8'h00);
        chk("R1", "rd_data", rd_data, 8'h00);
        chk("R1", "pop_data", pop_data, 8'h00);
    endtask

    task automatic t_lower_alias();
        wr(1'b0, 8'h30, 8'hA5);
        rd(1'b1, 8'h30, q);  chk("R2", "direct write, indirect read 30H", q, 8'hA5);
        wr(1'b1, 8'h31, 8'h3C);
        rd(1'b0, 8'h31, q);  chk("R2", "indirect write, direct read 31H", q, 8'h3C);
    endtask

    task automatic t_sfr_direct();
        wr(1'b1, 8'hA0, 8'h11);
        @(negedge clk);
        acc_valid = 1'b1; acc_we = 1'b1; acc_indirect = 1'b0; acc_addr = 8'hA0; acc_wdata = 8'h77;
        #1;
        chk("R3", "sfr_sel", {7'd0, sfr_sel}, 8'h01);
        chk("R3", "sfr_we", {7'd0, sfr_we}, 8'h01);
        chk("R3", "sfr_addr", sfr_addr, 8'hA0);
        chk("R3", "sfr_wdata", sfr_wdata, 8'h77);
        @(posedge clk); #1;
        acc_valid = 1'b0; acc_we = 1'b0;
        rd(1'b1, 8'hA0, q);  chk("R3", "upper RAM A0H untouched by direct write", q, 8'h11);
        rd(1'b0, 8'hA0, q);  chk("R5", "direct read A0H returns register data", q, 8'hFA);
    endtask

    task automatic t_upper_indirect();
        @(negedge clk);
        acc_valid = 1'b1; acc_we = 1'b1; acc_indirect = 1'b1; acc_addr = 8'hC5; acc_wdata = 8'h99;
        #1;
        chk("R4", "sfr_sel on indirect C5H", {7'd0, sfr_sel}, 8'h00);
        chk("R4", "sfr_we on indirect C5H", {7'd0, sfr_we}, 8'h00);
        @(posedge clk); #1;
        acc_valid = 1'b0; acc_we = 1'b0;
        rd(1'b1, 8'hC5, q);  chk("R4", "indirect read C5H", q, 8'h99);
        rd(1'b0, 8'hC5, q);  chk("R4", "direct read C5H still register", q, 8'h9F);
    endtask

    task automatic t_latency();
        wr(1'b1, 8'h40, 8'h5E);
        chk("R5", "rd_valid after write", {7'd0, rd_valid}, 8'h00);
        rd(1'b1, 8'h40, q);
        chk("R5", "rd_valid after read", {7'd0, rd_valid}, 8'h01);
        chk("R5", "rd_data after read", q, 8'h5E);
        cyc(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00);
        chk("R5", "rd_valid after idle", {7'd0, rd_valid}, 8'h00);
    endtask

    task automatic t_push_pop();
        push(8'h10);
        chk("R6", "sp after push", sp_value, 8'h08);
        rd(1'b1, 8'h08, q);  chk("R6", "pushed byte at 08H", q, 8'h10);
        pop();
        chk("R7", "pop_data", pop_data, 8'h10);
        chk("R7", "sp after pop", sp_value, 8'h07);
    endtask

    task automatic t_cross_upper();
        while (exp_sp != 8'h7F) push(exp_sp ^ 8'h33);
        push(8'hEE);
        chk("R6", "sp crosses into upper half", sp_value, 8'h80);
        rd(1'b1, 8'h80, q);  chk("R6", "stack byte in upper RAM 80H", q, 8'hEE);
        rd(1'b0, 8'h80, q);  chk("R6", "register 80H not hit by push", q, 8'hDA);
    endtask

    task automatic t_wrap();
        while (exp_sp != 8'hFF) push(exp_sp);
        push(8'h4B);
        chk("R8", "sp wraps FFH to 00H", sp_value, 8'h00);
        rd(1'b1, 8'h00, q);  chk("R8", "wrapped push lands at 00H", q, 8'h4B);
        pop();
        chk("R8", "pop_data at 00H", pop_data, 8'h4B);
        chk("R8", "sp wraps 00H to FFH", sp_value, 8'hFF);
    endtask

    task automatic t_both();
        cyc(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 8'h99);
        chk("R9", "sp unchanged on push+pop", sp_value, 8'hFF);
        rd(1'b1, 8'h00, q);  chk("R9", "no write on push+pop", q, 8'h4B);
    endtask

    task automatic t_conflict();
        wr(1'b1, 8'h00, 8'h21);
        cyc(1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0, 8'h22);
        exp_sp = exp_sp + 8'd1;
        chk("R10", "read during push same byte", rd_data, 8'h21);
        rd(1'b1, 8'h00, q);  chk("R10", "push value stored", q, 8'h22);
        cyc(1'b1, 1'b1, 1'b1, 8'h01, 8'h55, 1'b1, 1'b0, 8'h66);
        exp_sp = exp_sp + 8'd1;
        rd(1'b1, 8'h01, q);  chk("R11", "access write wins over push", q, 8'h55);
        chk("R11", "sp after colliding push", sp_value, 8'h01);
        cyc(1'b1, 1'b1, 1'b1, 8'h01, 8'h77, 1'b0, 1'b1, 8'h00);
        exp_sp = exp_sp - 8'd1;
        chk("R10", "pop during write same byte", pop_data, 8'h55);
        rd(1'b1, 8'h01, q);  chk("R10", "write after pop stored", q, 8'h77);
        chk("R7", "sp after colliding pop", sp_value, exp_sp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_lower_alias();
        t_sfr_direct();
        t_upper_indirect();
        t_latency();
        t_push_pop();
        t_cross_upper();
        t_wrap();
        t_both();
        t_conflict();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule